// File: doc/BRIEF.md
# Four-Channel Periodic Interrupt Timer

This block produces periodic time-outs on four independent channels. Two shared 8-bit prescaler counters, the micro time bases, each emit a one-cycle tick every `load + 1` clock cycles. Each channel has a 16-bit reload down-counter. The counter decrements only on the tick of the time base that the channel currently selects. When a channel counter is at zero on its tick, the channel raises a time-out flag and reloads on that same tick.

A per-channel interrupt line is the registered AND of the channel's flag and its enable bit. Software drives the block through a byte-wide register port with a single-cycle write strobe and a combinational read. Through this port it starts and stops the timer, sets the reload values, chooses a time base per channel, enables interrupts, and clears flags by writing 1 to them.

Register map: 0x0 control (bit 0 run), 0x1 time base 0 reload, 0x2 time base 1 reload, 0x3 time-base select, 0x4 interrupt enable, 0x5 time-out flags, and 0x6 + 2n / 0x7 + 2n for the low / high byte of the reload value of channel n.

Top module: `pit4_timer`

## Requirements
- R1: After reset every register reads 0x00, and all interrupt outputs are low.
- R2: In the select (0x3), enable (0x4) and flag (0x5) registers, bits 7:4 always read 0 and writes to them are ignored. Bits 3:0 belong to channels 3:0.
- R3: Take a channel with reload value C on a time base with reload value L. Its flag sets (C+1)*(L+1) clock edges after the edge that writes run=1. Further flags then follow every (C+1)*(L+1) edges.
- R4: A select bit of 0 makes the channel count on time base 0 (reload at 0x1). A select bit of 1 makes it count on time base 1 (reload at 0x2).
- R5: A change of a select bit takes effect on the next tick of the newly chosen time base. The channel does not wait for the current period to end.
- R6: While bit 0 of 0x0 is 0, all counters are held at their reload values and no flag becomes set.
- R7: Writing 1 to a bit of 0x5 clears that flag. Writing 0 leaves it unchanged.
- R8: When a time-out and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: Each interrupt output equals the AND of the channel's flag and enable bit, delayed by one clock edge. Setting an enable bit while the flag is pending raises the output one edge after the write, and clearing the flag drops it one edge after the clear.
- R10: Writes to the time-base reload registers (0x1, 0x2) and to the channel reload bytes (0x6 + 2n low, 0x7 + 2n high) read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 4 | Interrupt request per channel, level |

## Verification
A channel counter left in a wrong state shows up as a flag that is early or late by a whole number of prescaler periods. A wrong prescaler state shifts the flag by a fraction of a channel period. Both become visible at the flag register within a single period, (C+1)*(L+1) cycles. A wrong select wiring makes the period follow the reload value of the other time base, and a switch test exposes it within a few cycles. An enable or flag that is not held correctly appears on the irq pins one edge later.

// File: rtl/pit4_pkg.sv
package pit4_pkg;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_TB0  = 1;
  localparam int unsigned ADDR_SEL  = 3;
  localparam int unsigned ADDR_IEN  = 4;
  localparam int unsigned ADDR_FLG  = 5;
  localparam int unsigned ADDR_LD0  = 6;
  localparam int unsigned N_TB      = 2;
  localparam int unsigned DW        = 8;
endpackage

// File: rtl/pit4_tbase.sv
module pit4_tbase #(
  parameter int unsigned TBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [TBW-1:0] load,
  output logic           tick
);
  logic [TBW-1:0] cnt_q, cnt_n;

  assign tick = run && (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    if (!run || tick) cnt_n = load;
    else              cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/pit4_chan.sv
module pit4_chan #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] load,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_n;

  assign expire = run && tick && (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    if (!run || expire) cnt_n = load;
    else if (tick)      cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/pit4_regs.sv
module pit4_regs
  import pit4_pkg::*;
#(
  parameter int unsigned N_CH = 4,
  parameter int unsigned CW   = 16,
  parameter int unsigned TBW  = 8,
  parameter int unsigned AW   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [AW-1:0]                  addr,
  input  logic [DW-1:0]                  wdata,
  output logic [DW-1:0]                  rdata,
  input  logic [N_CH-1:0]                expire,
  output logic                           run,
  output logic [N_TB-1:0][TBW-1:0]       tb_load,
  output logic [N_CH-1:0][CW-1:0]        ch_load,
  output logic [N_CH-1:0]                ch_sel,
  output logic [N_CH-1:0]                ien,
  output logic [N_CH-1:0]                flags,
  output logic [N_CH-1:0]                irq
);
  localparam int unsigned CB = CW / DW;

  logic                      run_q, run_n;
  logic [N_TB-1:0][TBW-1:0]  tbl_q, tbl_n;
  logic [N_CH-1:0][CW-1:0]   chl_q, chl_n;
  logic [N_CH-1:0]           sel_q, sel_n, ien_q, ien_n, flg_q, flg_n, irq_q, irq_n;

  always_comb begin
    run_n = run_q;
    tbl_n = tbl_q;
    chl_n = chl_q;
    sel_n = sel_q;
    ien_n = ien_q;
    flg_n = flg_q;
    if (wr) begin
      if (addr == AW'(ADDR_CTRL)) run_n = wdata[0];
      if (addr == AW'(ADDR_SEL))  sel_n = wdata[N_CH-1:0];
      if (addr == AW'(ADDR_IEN))  ien_n = wdata[N_CH-1:0];
      if (addr == AW'(ADDR_FLG))  flg_n = flg_q & ~wdata[N_CH-1:0];
      for (int t = 0; t < int'(N_TB); t++)
        if (addr == AW'(int'(ADDR_TB0) + t)) tbl_n[t] = wdata[TBW-1:0];
      for (int n = 0; n < int'(N_CH); n++)
        for (int b = 0; b < int'(CB); b++)
          if (addr == AW'(int'(ADDR_LD0) + n * int'(CB) + b))
            chl_n[n][b*DW +: DW] = wdata;
    end
    flg_n = flg_n | expire;
    irq_n = flg_q & ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      tbl_q <= '0;
      chl_q <= '0;
      sel_q <= '0;
      ien_q <= '0;
      flg_q <= '0;
      irq_q <= '0;
    end else begin
      run_q <= run_n;
      tbl_q <= tbl_n;
      chl_q <= chl_n;
      sel_q <= sel_n;
      ien_q <= ien_n;
      flg_q <= flg_n;
      irq_q <= irq_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADDR_CTRL)) rdata[0] = run_q;
    if (addr == AW'(ADDR_SEL))  rdata[N_CH-1:0] = sel_q;
    if (addr == AW'(ADDR_IEN))  rdata[N_CH-1:0] = ien_q;
    if (addr == AW'(ADDR_FLG))  rdata[N_CH-1:0] = flg_q;
    for (int t = 0; t < int'(N_TB); t++)
      if (addr == AW'(int'(ADDR_TB0) + t)) rdata[TBW-1:0] = tbl_q[t];
    for (int n = 0; n < int'(N_CH); n++)
      for (int b = 0; b < int'(CB); b++)
        if (addr == AW'(int'(ADDR_LD0) + n * int'(CB) + b))
          rdata = chl_q[n][b*DW +: DW];
  end

  assign run     = run_q;
  assign tb_load = tbl_q;
  assign ch_load = chl_q;
  assign ch_sel  = sel_q;
  assign ien     = ien_q;
  assign flags   = flg_q;
  assign irq     = irq_q;
endmodule

// File: rtl/pit4_timer.sv
module pit4_timer
  import pit4_pkg::*;
#(
  parameter int unsigned N_CH = 4,
  parameter int unsigned CW   = 16,
  parameter int unsigned TBW  = 8,
  parameter int unsigned AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [N_CH-1:0] irq
);
  logic [1:0]               rst_sync_q;
  logic                     rst_sync_n;
  logic                     run;
  logic [N_TB-1:0][TBW-1:0] tb_load;
  logic [N_CH-1:0][CW-1:0]  ch_load;
  logic [N_CH-1:0]          ch_sel, ien, flags, expire;
  logic [N_TB-1:0]          tb_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pit4_regs #(.N_CH(N_CH), .CW(CW), .TBW(TBW), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .expire(expire), .run(run),
    .tb_load(tb_load), .ch_load(ch_load), .ch_sel(ch_sel), .ien(ien),
    .flags(flags), .irq(irq)
  );

  for (genvar t = 0; t < N_TB; t++) begin : g_tb
    pit4_tbase #(.TBW(TBW)) tb_i (
      .clk(clk), .rst_n(rst_sync_n), .run(run), .load(tb_load[t]), .tick(tb_tick[t])
    );
  end

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    pit4_chan #(.CW(CW)) ch_i (
      .clk(clk), .rst_n(rst_sync_n), .run(run), .tick(tb_tick[ch_sel[n]]),
      .load(ch_load[n]), .expire(expire[n])
    );
  end
endmodule

// File: rtl/pit4_timer_chk.sv
module pit4_timer_chk #(
  parameter int unsigned N_CH = 4,
  parameter int unsigned AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr,
  input logic [AW-1:0]   addr,
  input logic [7:0]      wdata,
  input logic [7:0]      rdata,
  input logic            run,
  input logic [N_CH-1:0] flg,
  input logic [N_CH-1:0] ien,
  input logic [N_CH-1:0] expire,
  input logic [N_CH-1:0] irq
);
  logic [N_CH-1:0] clr;
  assign clr = (wr && addr == AW'(5)) ? wdata[N_CH-1:0] : '0;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(3) || addr == AW'(4) || addr == AW'(5)) |-> (rdata[7:4] == 4'h0));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(flg & ien)));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flg & $past(flg & ~clr)) == $past(flg & ~clr)));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flg & $past(expire)) == $past(expire)));

  // R6
  stopped_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((flg & ~$past(flg)) == '0));
endmodule

bind pit4_timer pit4_timer_chk #(.N_CH(N_CH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .addr(reg_addr),
  .wdata(reg_wdata), .rdata(reg_rdata), .run(run), .flg(flags),
  .ien(ien), .expire(expire), .irq(irq)
);

// File: tb/pit4_timer_tb.sv
`timescale 1ns/1ps
module pit4_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] irq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pit4_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  tb;
    logic [15:0] ld;
    logic        sel;
    logic [1:0]  ch;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{tb: 8'd0, ld: 16'd0,  sel: 1'b0, ch: 2'd0},
    '{tb: 8'd3, ld: 16'd4,  sel: 1'b1, ch: 2'd1},
    '{tb: 8'd9, ld: 16'd2,  sel: 1'b0, ch: 2'd2},
    '{tb: 8'd1, ld: 16'd99, sel: 1'b1, ch: 2'd3}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    int m;
    int expc;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    tick_n(5);

    // R1 reset values
    for (int a = 0; a < 14; a++) begin
      rd(4'(a), d);
      check("R1", int'(d), 0);
    end
    check("R1 irq", int'(irq), 0);

    // R2 reserved bits
    do_wr(4'd3, 8'hFF); rd(4'd3, d); check("R2 sel", int'(d), 8'h0F);
    do_wr(4'd4, 8'hF0); rd(4'd4, d); check("R2 ien", int'(d), 8'h00);
    do_wr(4'd3, 8'h00);

    // R10 readback
    do_wr(4'd10, 8'h34); do_wr(4'd11, 8'h12); do_wr(4'd2, 8'hA5);
    rd(4'd10, d); check("R10 lo", int'(d), 8'h34);
    rd(4'd11, d); check("R10 hi", int'(d), 8'h12);
    rd(4'd2, d);  check("R10 tb1", int'(d), 8'hA5);

    // R3 / R4 period vectors
    foreach (VECS[i]) begin
      do_wr(4'd0, 8'h00);
      do_wr(4'd1 + 4'(VECS[i].sel), VECS[i].tb);
      do_wr(4'd6 + 4'(2 * VECS[i].ch), VECS[i].ld[7:0]);
      do_wr(4'd7 + 4'(2 * VECS[i].ch), VECS[i].ld[15:8]);
      do_wr(4'd3, 8'(VECS[i].sel) << VECS[i].ch);
      do_wr(4'd5, 8'h0F);
      expc = (int'(VECS[i].ld) + 1) * (int'(VECS[i].tb) + 1);
      do_wr(4'd0, 8'h01);
      n = 0;
      rd(4'd5, d);
      while (!d[VECS[i].ch] && n < 70000) begin
        @(posedge clk); #1; n++;
        rd(4'd5, d);
      end
      check("R3 R4 first period", n, expc);
      if (expc >= 3) begin
        do_wr(4'd5, 8'(1) << VECS[i].ch);
        m = 1;
        rd(4'd5, d);
        while (!d[VECS[i].ch] && m < 70000) begin
          @(posedge clk); #1; m++;
          rd(4'd5, d);
        end
        check("R3 repeat period", m, expc);
      end
    end

    // R5 immediate switch
    do_wr(4'd0, 8'h00);
    do_wr(4'd1, 8'd255); do_wr(4'd2, 8'd0);
    do_wr(4'd6, 8'd3); do_wr(4'd7, 8'd0);
    do_wr(4'd3, 8'h00); do_wr(4'd5, 8'h0F);
    do_wr(4'd0, 8'h01);
    do_wr(4'd3, 8'h01);
    n = 0;
    rd(4'd5, d);
    while (!d[0] && n < 1000) begin
      @(posedge clk); #1; n++;
      rd(4'd5, d);
    end
    check("R5 switch", n, 4);
    do_wr(4'd0, 8'h00);

    // R9 interrupt with pending flag
    rd(4'd5, d); check("R9 flag pending", int'(d[0]), 1);
    tick_n(2);
    check("R9 disabled irq", int'(irq[0]), 0);
    do_wr(4'd4, 8'h01);
    check("R9 irq not yet", int'(irq[0]), 0);
    tick_n(1);
    check("R9 irq raised", int'(irq[0]), 1);

    // R7 write-one-to-clear
    do_wr(4'd5, 8'h00); rd(4'd5, d);
    check("R7 write 0", int'(d[0]), 1);
    check("R9 irq held", int'(irq[0]), 1);
    do_wr(4'd5, 8'h01); rd(4'd5, d);
    check("R7 write 1", int'(d[0]), 0);
    tick_n(1);
    check("R9 irq dropped", int'(irq[0]), 0);

    // R8 set wins over clear
    do_wr(4'd4, 8'h00);
    do_wr(4'd8, 8'd0); do_wr(4'd9, 8'd0);
    do_wr(4'd3, 8'h02);
    do_wr(4'd0, 8'h01);
    tick_n(3);
    do_wr(4'd5, 8'h02); rd(4'd5, d);
    check("R8 set wins", int'(d[1]), 1);

    // R6 hold while stopped
    do_wr(4'd0, 8'h00);
    do_wr(4'd5, 8'h0F);
    tick_n(20);
    rd(4'd5, d);
    check("R6 stopped", int'(d), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule